// File: doc/BRIEF.md
# Enable and Synchronization Pin Decoder

This block watches one digital input that does two jobs. A steady high level starts the switching regulator. A steady low level puts it to sleep. A square wave on the same input serves as an external switching clock. The pin is sampled on a fast system clock and passed through a synchronizer. The block then classifies the pin by measuring the spacing of its falling edges and the length of its low phases against the nominal switching period. That period is a parameter counted in system clocks.

The block produces three outputs:
- a run/sleep status;
- a sync-lock flag;
- a one-clock cycle-start pulse.

When lock is held, the cycle-start pulse follows accepted falling edges of the pin. Otherwise it comes from an internal phase counter with the nominal period. An undervoltage flag forces the regulator off. If that flag rises while the pin is high, the block does not restart when the flag clears. It waits for the pin to go low and then high again.

Top module: `pin_mode_decoder`

## Requirements
- R1: After reset the block is asleep: `run_o` is 0, `sleep_o` is 1, `sync_lock_o` is 0 and no cycle-start pulse appears while the pin stays low.
- R2: With the undervoltage flag low and no restart block pending, a high level on the pin sets `run_o` within 4 system clocks, and `sleep_o` is always the inverse of `run_o`.
- R3: While running without lock, `cycle_start_o` pulses once every `PERIOD_CLKS` system clocks.
- R4: A falling edge is accepted, and sets `sync_lock_o`, when three conditions hold. First, the previous falling edge came no more than the timeout earlier. Second, a rising edge lies between the two falling edges. Third, the spacing between the falling edges lies in [`MIN_SYNC_CLKS`, `PERIOD_CLKS`*5/4]. Each accepted edge produces a cycle-start pulse within 4 system clocks of the pin change.
- R5: While locked, cycle-start pulses come only from accepted falling edges, so each sync period yields exactly one pulse.
- R6: A falling-edge spacing below `MIN_SYNC_CLKS` (too fast) or above `PERIOD_CLKS`*5/4 (slower than 80 % of nominal) never produces lock.
- R7: The low phase must last at least 1/4 and at most 3/4 of the falling-edge spacing for an edge to be accepted. A low phase of 5 clocks in a 22-clock period is rejected. A low phase of 6 clocks in the same period is accepted.
- R8: When no falling edge follows within `PERIOD_CLKS`*7/2 clocks of the last one, lock is dropped. Running continues, and pulses resume from the internal counter at the nominal period.
- R9: Running ends only after the pin has been low for more than 7*`PERIOD_CLKS` consecutive clocks. A shorter low has no effect on `run_o`. No cycle-start pulse appears while not running.
- R10: The undervoltage flag clears `run_o` on the next clock, and no pulses appear while it is held.
- R11: If the undervoltage flag is seen while the pin is high, `run_o` stays 0 after the flag clears until the pin goes low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Raw enable/sync pin, asynchronous |
| uv_i | input | 1 | Undervoltage flag, active high |
| run_o | output | 1 | Regulator enabled |
| sleep_o | output | 1 | Regulator in sleep |
| sync_lock_o | output | 1 | External sync accepted |
| cycle_start_o | output | 1 | One-clock pulse marking a switching cycle start |

## Verification
The hardest condition to reach is the edge of the sync acceptance window. Lock depends on two consecutive falling edges that satisfy the spacing rule and the low-phase fraction at the same time. The stimulus therefore drives exact square waves whose period and low time are counted in system clocks. It places one burst just outside each limit and one just inside the duty limit. Lock loss is reached by stopping a locked wave with the pin held high. The lock flag is then sampled on both sides of the timeout. The pulse cadence after fallback is counted separately.

// File: rtl/ensd_pkg.sv
package ensd_pkg;
  // Clocks without a falling edge before the pin is taken as a static level.
  function automatic int unsigned timeout_clks(input int unsigned period);
    return (period * 7) / 2;
  endfunction

  // Longest accepted sync spacing: frequency at least 80 % of nominal.
  function automatic int unsigned slow_limit(input int unsigned period);
    return (period * 5) / 4;
  endfunction

  // Low run needed before the regulator is switched off.
  function automatic int unsigned off_clks(input int unsigned period);
    return period * 7;
  endfunction
endpackage

// File: rtl/ensd_pin_front.sv
module ensd_pin_front #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], pin_i};
  end

  assign level_o = shreg[STAGES-1];
  assign rise_o  = shreg[STAGES-1] & ~shreg[STAGES];
  assign fall_o  = ~shreg[STAGES-1] & shreg[STAGES];
endmodule

// File: rtl/ensd_power_gate.sv
module ensd_power_gate #(
  parameter int unsigned OFF_LIM = 140
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic uv_i,
  output logic run_o
);
  localparam int unsigned LW = $clog2(OFF_LIM + 1);

  logic [LW-1:0] low_run;
  logic          blocked;
  logic          running;
  logic          low_expired;

  assign low_expired = !level_i && (low_run == LW'(OFF_LIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
      blocked <= 1'b0;
      running <= 1'b0;
    end else begin
      if (level_i)                    low_run <= '0;
      else if (low_run != LW'(OFF_LIM)) low_run <= low_run + 1'b1;

      if (uv_i && level_i) blocked <= 1'b1;
      else if (!level_i)   blocked <= 1'b0;

      if (uv_i)                                running <= 1'b0;
      else if (low_expired)                    running <= 1'b0;
      else if (level_i && !blocked && !running) running <= 1'b1;
    end
  end

  assign run_o = running;
endmodule

// File: rtl/ensd_sync_qual.sv
module ensd_sync_qual #(
  parameter int unsigned MIN_CLKS = 18,
  parameter int unsigned MAX_CLKS = 25,
  parameter int unsigned TMO_CLKS = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic good_fall_o,
  output logic lock_o
);
  localparam int unsigned CW = $clog2(TMO_CLKS + 1);
  localparam int unsigned MW = CW + 1;
  localparam int unsigned XW = CW + 3;

  logic [CW-1:0] since_fall;
  logic [MW-1:0] low_len;
  logic [MW-1:0] span;
  logic [XW-1:0] low_x4;
  logic [XW-1:0] span_x1;
  logic [XW-1:0] span_x3;
  logic          have_prev;
  logic          have_rise;
  logic          lock_q;
  logic          span_ok;
  logic          duty_ok;
  logic          good;
  logic          expire;

  assign span    = {1'b0, since_fall} + 1'b1;
  assign low_x4  = {low_len, 2'b00};
  assign span_x1 = {2'b00, span};
  assign span_x3 = {2'b00, span} + {1'b0, span, 1'b0};
  assign span_ok = (span >= MW'(MIN_CLKS)) && (span <= MW'(MAX_CLKS));
  assign duty_ok = (low_x4 >= span_x1) && (low_x4 <= span_x3);
  assign good    = fall_i && have_prev && have_rise && span_ok && duty_ok;
  assign expire  = !fall_i && (since_fall == CW'(TMO_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_fall <= '0;
      low_len    <= '0;
      have_prev  <= 1'b0;
      have_rise  <= 1'b0;
      lock_q     <= 1'b0;
    end else begin
      if (fall_i) begin
        since_fall <= '0;
        have_prev  <= 1'b1;
        have_rise  <= 1'b0;
      end else begin
        if (since_fall != CW'(TMO_CLKS)) since_fall <= since_fall + 1'b1;
        if (expire) have_prev <= 1'b0;
        if (rise_i && have_prev) begin
          low_len   <= span;
          have_rise <= 1'b1;
        end
      end

      if (!run_i)      lock_q <= 1'b0;
      else if (fall_i) lock_q <= good;
      else if (expire) lock_q <= 1'b0;
    end
  end

  assign good_fall_o = good && run_i;
  assign lock_o      = lock_q;
endmodule

// File: rtl/ensd_cycle_gen.sv
module ensd_cycle_gen #(
  parameter int unsigned PERIOD_CLKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic lock_i,
  input  logic good_fall_i,
  output logic pulse_o
);
  localparam int unsigned PW = $clog2(PERIOD_CLKS);

  logic [PW-1:0] phase;
  logic          wrap;

  assign wrap = (phase == PW'(PERIOD_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      pulse_o <= 1'b0;
    end else begin
      if (!run_i || good_fall_i || wrap) phase <= '0;
      else                               phase <= phase + 1'b1;
      pulse_o <= run_i && (good_fall_i || (wrap && !lock_i));
    end
  end
endmodule

// File: rtl/pin_mode_decoder.sv
module pin_mode_decoder
  import ensd_pkg::*;
#(
  parameter int unsigned PERIOD_CLKS   = 20,
  parameter int unsigned MIN_SYNC_CLKS = 18,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic uv_i,
  output logic run_o,
  output logic sleep_o,
  output logic sync_lock_o,
  output logic cycle_start_o
);
  localparam int unsigned TMO_CLKS  = timeout_clks(PERIOD_CLKS);
  localparam int unsigned SLOW_CLKS = slow_limit(PERIOD_CLKS);
  localparam int unsigned OFF_CLKS  = off_clks(PERIOD_CLKS);

  logic level, rise, fall;
  logic running, lock, good_fall;

  ensd_pin_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  ensd_power_gate #(.OFF_LIM(OFF_CLKS)) u_gate (
    .clk(clk), .rst_n(rst_n), .level_i(level), .uv_i(uv_i), .run_o(running)
  );

  ensd_sync_qual #(
    .MIN_CLKS(MIN_SYNC_CLKS), .MAX_CLKS(SLOW_CLKS), .TMO_CLKS(TMO_CLKS)
  ) u_qual (
    .clk(clk), .rst_n(rst_n), .run_i(running), .rise_i(rise), .fall_i(fall),
    .good_fall_o(good_fall), .lock_o(lock)
  );

  ensd_cycle_gen #(.PERIOD_CLKS(PERIOD_CLKS)) u_cyc (
    .clk(clk), .rst_n(rst_n), .run_i(running), .lock_i(lock),
    .good_fall_i(good_fall), .pulse_o(cycle_start_o)
  );

  assign run_o       = running;
  assign sleep_o     = ~running;
  assign sync_lock_o = lock;
endmodule

// File: rtl/ensd_checker.sv
module ensd_checker (
  input logic clk,
  input logic rst_n,
  input logic pin_i,
  input logic uv_i,
  input logic run_o,
  input logic sync_lock_o,
  input logic cycle_start_o
);
  AST_UV_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> !run_o); // R10

  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |=> !cycle_start_o); // R9

  AST_LOCK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |=> !sync_lock_o); // R4

  AST_START_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> (!$past(uv_i) && $past(pin_i, 2))); // R11

  AST_STOP_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run_o) && !$past(uv_i)) |-> !$past(pin_i, 2)); // R9
endmodule

bind pin_mode_decoder ensd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .uv_i(uv_i),
  .run_o(run_o), .sync_lock_o(sync_lock_o), .cycle_start_o(cycle_start_o)
);

// File: tb/pin_mode_decoder_tb.sv
module pin_mode_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic uv = 1'b0;
  logic run, sleep, lock, cstart;

  int checks = 0;
  int failures = 0;
  int pcount = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pin_mode_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .uv_i(uv),
    .run_o(run), .sleep_o(sleep), .sync_lock_o(lock), .cycle_start_o(cstart)
  );

  always @(negedge clk) if (cstart) pcount++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic square(input int period, input int low, input int count);
    for (int i = 0; i < count; i++) begin
      pin = 1'b0; wait_n(low);
      pin = 1'b1; wait_n(period - low);
    end
  endtask

  task automatic t_reset;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(10);
    check(run == 0, "R1 run after reset", run, 0);
    check(sleep == 1, "R1 sleep after reset", sleep, 1);
    check(lock == 0 && pcount == 0, "R1 lock/pulses after reset", pcount + lock, 0);
  endtask

  task automatic t_wake;
    int c0;
    pin = 1'b1;
    wait_n(4);
    check(run == 1, "R2 run after high level", run, 1);
    check(sleep == 0, "R2 sleep inverse", sleep, 0);
    wait_n(25);
    c0 = pcount;
    wait_n(200);
    check(pcount - c0 == 10, "R3 internal pulses in 200 clocks", pcount - c0, 10);
  endtask

  task automatic t_sync_good;
    int c0, n;
    square(22, 11, 6);
    check(lock == 1, "R4 lock on valid sync", lock, 1);
    c0 = pcount;
    square(22, 11, 5);
    check(pcount - c0 == 5, "R5 one pulse per sync period", pcount - c0, 5);
    pin = 1'b0;
    n = 0;
    c0 = pcount;
    while (pcount == c0 && n < 8) begin
      wait_n(1);
      n++;
    end
    check(n >= 1 && n <= 4, "R4 pulse latency after fall", n, 3);
    wait_n(11 - n);
    pin = 1'b1;
    wait_n(11);
  endtask

  task automatic t_timeout;
    int c0;
    wait_n(35);
    check(lock == 1, "R8 lock held before timeout", lock, 1);
    wait_n(25);
    check(lock == 0, "R8 lock dropped after timeout", lock, 0);
    check(run == 1, "R8 still running after unlock", run, 1);
    c0 = pcount;
    wait_n(100);
    check(pcount - c0 >= 4 && pcount - c0 <= 6, "R8 internal cadence resumes", pcount - c0, 5);
  endtask

  task automatic t_range;
    square(14, 7, 8);
    check(lock == 0, "R6 too fast rejected", lock, 0);
    square(30, 15, 6);
    check(lock == 0, "R6 too slow rejected", lock, 0);
    check(run == 1, "R6 slow wave keeps running", run, 1);
  endtask

  task automatic t_duty;
    square(22, 3, 6);
    check(lock == 0, "R7 short low rejected", lock, 0);
    square(22, 19, 6);
    check(lock == 0, "R7 long low rejected", lock, 0);
    square(22, 5, 6);
    check(lock == 0, "R7 low 5 of 22 rejected", lock, 0);
    square(22, 6, 6);
    check(lock == 1, "R7 low 6 of 22 accepted", lock, 1);
  endtask

  task automatic t_off;
    int c0;
    pin = 1'b0; wait_n(130);
    pin = 1'b1; wait_n(3);
    check(run == 1, "R9 short low ignored", run, 1);
    wait_n(5);
    pin = 1'b0; wait_n(160);
    check(run == 0, "R9 long low stops", run, 0);
    check(sleep == 1, "R9 sleep after long low", sleep, 1);
    c0 = pcount;
    wait_n(50);
    check(pcount == c0, "R9 no pulses asleep", pcount - c0, 0);
  endtask

  task automatic t_uv;
    int c0;
    pin = 1'b1; wait_n(6);
    check(run == 1, "R2 wake again", run, 1);
    uv = 1'b1; wait_n(2);
    check(run == 0, "R10 undervoltage stops", run, 0);
    c0 = pcount;
    wait_n(30);
    check(pcount == c0, "R10 no pulses under undervoltage", pcount - c0, 0);
    uv = 1'b0; wait_n(40);
    check(run == 0, "R11 no restart while pin stays high", run, 0);
    pin = 1'b0; wait_n(4);
    pin = 1'b1; wait_n(5);
    check(run == 1, "R11 restart after low-high", run, 1);
  endtask

  initial begin
    t_reset();
    t_wake();
    t_sync_good();
    t_timeout();
    t_range();
    t_duty();
    t_off();
    t_uv();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule